// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block keeps the interrupt status and control registers of a full-speed USB device core and drives a single interrupt request toward the processor. Single-cycle event pulses from the protocol engine set sticky status flags. Software clears a flag by writing a zero to its position; a written one leaves the flag alone. This allows a service routine to clear exactly the events it handled, without a read-modify-write.

Each endpoint reports a completed transaction on its own input. The block keeps a pending flag per endpoint and shows a read-only summary flag in the status word. It also reports the number and transfer direction of the lowest pending endpoint. A pending endpoint flag is cleared only through that endpoint's clear input. While any endpoint is pending, a separate endpoint interrupt output is high, whatever the mask says.

The control word holds one enable bit per status flag, plus two mode bits. Force-reset holds the core in its USB reset state. Power-down disconnects the transceiver. Register reads are combinational. Register writes take effect at the next clock edge.

Top module: `usbirq_ctrl`

## Requirements
- R1: After reset (synchronous, active-low), the control word and status word both read 0. `irq_o`, `ep_irq_o`, `core_reset_o` and `xcvr_disconnect_o` are all 0.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit 8+k. The bits are: k=0 missed start-of-frame (bit 8), 1 start-of-frame (bit 9), 2 bus reset (bit 10), 3 suspend (bit 11), 4 wakeup (bit 12), 5 error (bit 13), 6 packet-memory overrun (bit 14). The bit reads 1 from the clock edge that samples the pulse and stays set without further pulses.
- R3: A write to the status word (`reg_addr_i`=1) clears each of bits 14:8 whose written value is 0. Bits written as 1 keep their value.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 15, the direction bit (bit 4) and the endpoint number (bits 3:0) are unaffected by status writes. Bits 7:5 always read 0.
- R6: `irq_o` is 1 exactly while some status bit in 15:8 and the control bit at the same position are both 1. Several pending sources give one level request. The request stays high until every enabled pending bit is cleared.
- R7: A pulse on `ep_done_i[n]` makes endpoint n pending from the next edge. Status bit 15 is the OR of all pending endpoints. A pulse on `ep_clr_i[n]` clears endpoint n, unless a completion arrives for it in the same cycle, in which case it stays pending.
- R8: `ep_irq_o` is 1 while any endpoint is pending, independent of control bit 15.
- R9: Bits 3:0 give the lowest-numbered pending endpoint. Bit 4 gives its direction as captured with its completion (`ep_dir_out_i`=1 for OUT/SETUP reads 1, IN reads 0). Both read 0 when nothing is pending.
- R10: Control bit 0 drives `core_reset_o`. While it is 1, status bit 10 is set again every cycle, so a clearing write cannot remove it.
- R11: Control bit 1 drives `xcvr_disconnect_o`.
- R12: A control write (`reg_addr_i`=0) stores bits 15:8 and 1:0. Control bits 7:2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register (combinational) |
| evt_i | input | 7 | Event pulses for status bits 14:8 |
| ep_done_i | input | NUM_EP | Per-endpoint transaction-complete pulses |
| ep_dir_out_i | input | NUM_EP | Direction of each completion, 1 = OUT/SETUP |
| ep_clr_i | input | NUM_EP | Per-endpoint pending clear pulses |
| irq_o | output | 1 | Combined masked interrupt request |
| ep_irq_o | output | 1 | Endpoint interrupt, unmasked |
| core_reset_o | output | 1 | Holds the core in USB reset |
| xcvr_disconnect_o | output | 1 | Disconnects the transceiver |

## Verification
Every stored result is due exactly one clock edge after its stimulus. This covers event flags, endpoint pending flags, captured direction, and control bits. The interrupt outputs and the read data are combinational from those registers, so they are valid after that same edge. The one exception is force-reset: it first sets the control bit, and the bus-reset flag follows one edge later. The bench therefore reads bit 10 after a second edge. All inputs are driven on the falling edge, one rising edge is allowed to pass, and results are read just after the next falling edge, so each check lands on the cycle the requirement names.

// File: rtl/usbirq_pkg.sv
// Package: shared widths and bit positions for the USB interrupt status controller.
// Assumes a 16-bit register word. Status flags occupy bits 15:8, and the
// endpoint number and direction occupy the low byte.
package usbirq_pkg;
    localparam int WORD_W      = 16;
    localparam int EVT_N       = 7;   // hardware event flags, bits 14:8
    localparam int EVT_LSB     = 8;   // status bit of evt_i[0]
    localparam int MASK_W      = 8;   // enable bits 15:8
    localparam int ID_W        = 4;   // endpoint number field width
    localparam int RST_EVT_IDX = 2;   // event index of the bus-reset flag (bit 10)
    localparam int CTL_FRES    = 0;
    localparam int CTL_PDWN    = 1;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/usbirq_sticky_bank.sv
// Sticky event flags: one set-dominant flip-flop per hardware event.
// Assumes set_i are single-cycle pulses (a held level just keeps the flag set).
// clr_i is already qualified by the register write, one strobe per flag.
module usbirq_sticky_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] bits_o
);
    logic [N-1:0] bits_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        // Set wins over clear so an event arriving with a clear is kept.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits_q[g] <= 1'b0;
            else if (set_i[g])
                bits_q[g] <= 1'b1;
            else if (clr_i[g])
                bits_q[g] <= 1'b0;
        end

        // R2
        set_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> bits_q[g]);
        // R3
        clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !bits_q[g]);
        // R3
        idle_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[g] && !set_i[g]) |=> $stable(bits_q[g]));
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/usbirq_ep_track.sv
// Per-endpoint completion tracking. It keeps one pending flag and one captured
// direction per endpoint, and picks the lowest-numbered pending endpoint.
// Assumes 2 <= NUM_EP <= 2**ID_W. Completion wins over a same-cycle clear.
module usbirq_ep_track #(
    parameter int NUM_EP = 8,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] done_i,
    input  logic [NUM_EP-1:0] dir_out_i,
    input  logic [NUM_EP-1:0] clr_i,
    output logic              any_o,
    output logic [ID_W-1:0]   id_o,
    output logic              dir_o
);
    localparam int IDX_W = $clog2(NUM_EP);

    logic [NUM_EP-1:0] pend_q;
    logic [NUM_EP-1:0] dir_q;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        // Pending flag: completion sets, clear input drops it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (done_i[g])
                pend_q[g] <= 1'b1;
            else if (clr_i[g])
                pend_q[g] <= 1'b0;
        end

        // Direction capture on each completion.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dir_q[g] <= 1'b0;
            else if (done_i[g])
                dir_q[g] <= dir_out_i[g];
        end

        // R7
        done_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_i[g] |=> pend_q[g]);
        // R7
        clr_unpends_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !done_i[g]) |=> !pend_q[g]);
    end

    // Lowest pending endpoint: scan downward so the smallest index is kept.
    always_comb begin
        id_o  = '0;
        dir_o = 1'b0;
        for (int i = NUM_EP - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                id_o  = ID_W'(i);
                dir_o = dir_q[i];
            end
        end
    end

    assign any_o = |pend_q;

    // R9
    id_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_q[id_o[IDX_W-1:0]]);
    // R9
    idle_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_o |-> (id_o == '0 && !dir_o));
endmodule

// File: rtl/usbirq_ctrl_reg.sv
// Control register: enable bits for status flags 15:8 plus force-reset and
// power-down mode bits. Unimplemented positions read as zero.
// Assumes wr_i is already qualified with the control register select.
module usbirq_ctrl_reg
    import usbirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [MASK_W-1:0] mask_wdata_i,
    input  logic [1:0]        mode_wdata_i,
    output logic [MASK_W-1:0] mask_o,
    output logic              fres_o,
    output logic              pdwn_o,
    output word_t             rdata_o
);
    logic [MASK_W-1:0] mask_q;
    logic [1:0]        mode_q;

    // Store enable and mode bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= '0;
        end else if (wr_i) begin
            mask_q <= mask_wdata_i;
            mode_q <= mode_wdata_i;
        end
    end

    assign mask_o  = mask_q;
    assign fres_o  = mode_q[CTL_FRES];
    assign pdwn_o  = mode_q[CTL_PDWN];
    assign rdata_o = {mask_q, 6'b0, mode_q};

    // R12
    ctl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> rdata_o == {$past(mask_wdata_i), 6'b0, $past(mode_wdata_i)});
    // R12
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(rdata_o));
endmodule

// File: rtl/usbirq_ctrl.sv
// Top: USB device interrupt status controller. It combines the sticky event
// flags, the endpoint tracker and the control register into a 16-bit status
// word and the request lines. Assumes a 1-bit register address
// (0 control, 1 status), combinational reads, and writes taking effect at the
// next edge.
module usbirq_ctrl
    import usbirq_pkg::*;
#(
    parameter int NUM_EP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    input  logic [6:0]        evt_i,
    input  logic [NUM_EP-1:0] ep_done_i,
    input  logic [NUM_EP-1:0] ep_dir_out_i,
    input  logic [NUM_EP-1:0] ep_clr_i,
    output logic              irq_o,
    output logic              ep_irq_o,
    output logic              core_reset_o,
    output logic              xcvr_disconnect_o
);
    logic              wr_stat;
    logic              wr_ctl;
    logic [EVT_N-1:0]  evt_set;
    logic [EVT_N-1:0]  evt_clr;
    logic [EVT_N-1:0]  sticky;
    logic              ep_any;
    logic [ID_W-1:0]   ep_id;
    logic              ep_dir;
    logic [MASK_W-1:0] mask;
    logic              fres;
    logic              pdwn;
    word_t             ctl_rdata;
    word_t             status_w;
    logic [MASK_W-1:0] flags;
    logic              unused_wbits;

    assign wr_stat = reg_wr_i && reg_addr_i;
    assign wr_ctl  = reg_wr_i && !reg_addr_i;

    // Event set vector: force-reset keeps re-raising the bus-reset flag.
    always_comb begin
        evt_set = evt_i;
        evt_set[RST_EVT_IDX] = evt_i[RST_EVT_IDX] | fres;
    end

    // Write-zero-to-clear strobes for the sticky flags.
    always_comb begin
        evt_clr = '0;
        if (wr_stat)
            evt_clr = ~reg_wdata_i[EVT_LSB +: EVT_N];
    end

    usbirq_sticky_bank #(.N(EVT_N)) sticky_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_set),
        .clr_i  (evt_clr),
        .bits_o (sticky)
    );

    usbirq_ep_track #(.NUM_EP(NUM_EP), .ID_W(ID_W)) ep_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (ep_done_i),
        .dir_out_i (ep_dir_out_i),
        .clr_i     (ep_clr_i),
        .any_o     (ep_any),
        .id_o      (ep_id),
        .dir_o     (ep_dir)
    );

    usbirq_ctrl_reg ctl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_ctl),
        .mask_wdata_i (reg_wdata_i[15:8]),
        .mode_wdata_i (reg_wdata_i[1:0]),
        .mask_o       (mask),
        .fres_o       (fres),
        .pdwn_o       (pdwn),
        .rdata_o      (ctl_rdata)
    );

    // Status word assembly and read multiplexer.
    assign status_w    = {ep_any, sticky, 3'b000, ep_dir, ep_id};
    assign reg_rdata_o = reg_addr_i ? status_w : ctl_rdata;

    // Request lines and mode outputs.
    assign flags             = status_w[15:8];
    assign irq_o             = |(flags & mask);
    assign ep_irq_o          = ep_any;
    assign core_reset_o      = fres;
    assign xcvr_disconnect_o = pdwn;

    assign unused_wbits = ^reg_wdata_i[7:2];

    // R6
    irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !reg_wr_i && ep_clr_i == '0) |=> irq_o);
    // R5
    ro_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && ep_done_i == '0 && ep_clr_i == '0)
        |=> ($stable(status_w[15]) && $stable(status_w[4:0])));
    // R10
    fres_rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset_o |=> status_w[10]);
    // R8
    ep_irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w[15] && !mask[7]) |-> (ep_irq_o && !(irq_o && flags[6:0] == '0)));
endmodule

// File: tb/usbirq_ctrl_tb_top.sv
`timescale 1ns/100ps
module usbirq_ctrl_tb_top;
    localparam int NUM_EP = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_i = 1'b0;
    logic              reg_addr_i = 1'b0;
    logic [15:0]       reg_wdata_i = '0;
    logic [15:0]       reg_rdata_o;
    logic [6:0]        evt_i = '0;
    logic [NUM_EP-1:0] ep_done_i = '0;
    logic [NUM_EP-1:0] ep_dir_out_i = '0;
    logic [NUM_EP-1:0] ep_clr_i = '0;
    logic              irq_o, ep_irq_o, core_reset_o, xcvr_disconnect_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    usbirq_ctrl #(.NUM_EP(NUM_EP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .evt_i(evt_i), .ep_done_i(ep_done_i), .ep_dir_out_i(ep_dir_out_i),
        .ep_clr_i(ep_clr_i), .irq_o(irq_o), .ep_irq_o(ep_irq_o),
        .core_reset_o(core_reset_o), .xcvr_disconnect_o(xcvr_disconnect_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic write_reg(input logic addr, input logic [15:0] data);
        reg_wr_i = 1'b1; reg_addr_i = addr; reg_wdata_i = data;
        cyc();
        reg_wr_i = 1'b0;
        #0.5;
    endtask

    task automatic read_reg(input logic addr, output logic [15:0] data);
        reg_addr_i = addr;
        #0.5;
        data = reg_rdata_o;
    endtask

    task automatic pulse_evt(input int k);
        evt_i[k] = 1'b1;
        cyc();
        evt_i = '0;
        #0.5;
    endtask

    task automatic pulse_ep(input logic [NUM_EP-1:0] done, input logic [NUM_EP-1:0] dout,
                            input logic [NUM_EP-1:0] clr);
        ep_done_i = done; ep_dir_out_i = dout; ep_clr_i = clr;
        cyc();
        ep_done_i = '0; ep_dir_out_i = '0; ep_clr_i = '0;
        #0.5;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        read_reg(1'b0, v); check("R1 control", v, 16'h0000);
        read_reg(1'b1, v); check("R1 status", v, 16'h0000);
        check("R1 outputs", {12'b0, irq_o, ep_irq_o, core_reset_o, xcvr_disconnect_o}, 16'h0);
    endtask

    task automatic t_sticky();
        logic [15:0] v;
        pulse_evt(3);
        read_reg(1'b1, v); check("R2 suspend set", v, 16'h0800);
        check("R6 masked no irq", {15'b0, irq_o}, 16'h0);
        repeat (3) cyc();
        read_reg(1'b1, v); check("R2 stays set", v, 16'h0800);
        pulse_evt(6);
        read_reg(1'b1, v); check("R2 overrun set", v, 16'h4800);
        write_reg(1'b1, 16'h0000);
        read_reg(1'b1, v); check("R3 clear all", v, 16'h0000);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        pulse_evt(0);
        pulse_evt(3);
        read_reg(1'b1, v); check("R2 two flags", v, 16'h0900);
        write_reg(1'b1, 16'hFEFF);
        read_reg(1'b1, v); check("R3 clear bit8 only", v, 16'h0800);
        write_reg(1'b1, 16'hFFFF);
        read_reg(1'b1, v); check("R3 ones keep", v, 16'h0800);
        write_reg(1'b1, 16'h0000);
        read_reg(1'b1, v); check("R3 zeros clear", v, 16'h0000);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        evt_i[1] = 1'b1;
        reg_wr_i = 1'b1; reg_addr_i = 1'b1; reg_wdata_i = 16'h0000;
        cyc();
        evt_i = '0; reg_wr_i = 1'b0;
        read_reg(1'b1, v); check("R4 set beats clear", v, 16'h0200);
        write_reg(1'b1, 16'h0000);
        read_reg(1'b1, v); check("R4 later clear", v, 16'h0000);
    endtask

    task automatic t_irq();
        pulse_evt(1);
        write_reg(1'b0, 16'h3000);
        check("R6 unmasked flag no irq", {15'b0, irq_o}, 16'h0);
        pulse_evt(4);
        check("R6 irq on enabled flag", {15'b0, irq_o}, 16'h1);
        pulse_evt(5);
        write_reg(1'b1, 16'hEFFF);
        check("R6 irq held by other flag", {15'b0, irq_o}, 16'h1);
        write_reg(1'b1, 16'hDFFF);
        check("R6 irq drops", {15'b0, irq_o}, 16'h0);
        write_reg(1'b1, 16'h0000);
        write_reg(1'b0, 16'h0000);
    endtask

    task automatic t_endpoints();
        logic [15:0] v;
        pulse_ep(8'h04, 8'h04, 8'h00);
        read_reg(1'b1, v); check("R7 R9 ep2 out", v, 16'h8012);
        check("R8 ep irq unmasked", {14'b0, ep_irq_o, irq_o}, 16'h2);
        write_reg(1'b1, 16'h0000);
        read_reg(1'b1, v); check("R5 read-only fields", v, 16'h8012);
        write_reg(1'b0, 16'h8000);
        check("R6 irq on bit15", {15'b0, irq_o}, 16'h1);
        pulse_ep(8'h20, 8'h00, 8'h00);
        read_reg(1'b1, v); check("R9 lowest wins", v, 16'h8012);
        pulse_ep(8'h00, 8'h00, 8'h04);
        read_reg(1'b1, v); check("R9 next ep5 in", v, 16'h8005);
        pulse_ep(8'h20, 8'h20, 8'h20);
        read_reg(1'b1, v); check("R7 done beats clr", v, 16'h8015);
        pulse_ep(8'h00, 8'h00, 8'h20);
        read_reg(1'b1, v); check("R7 all cleared", v, 16'h0000);
        check("R8 ep irq low", {14'b0, ep_irq_o, irq_o}, 16'h0);
        write_reg(1'b0, 16'h0000);
    endtask

    task automatic t_fres();
        logic [15:0] v;
        write_reg(1'b0, 16'h0001);
        check("R10 core reset", {15'b0, core_reset_o}, 16'h1);
        cyc();
        read_reg(1'b1, v); check("R10 reset flag", v, 16'h0400);
        write_reg(1'b1, 16'h0000);
        read_reg(1'b1, v); check("R10 flag held", v, 16'h0400);
        write_reg(1'b0, 16'h0000);
        check("R10 core reset off", {15'b0, core_reset_o}, 16'h0);
        write_reg(1'b1, 16'h0000);
        read_reg(1'b1, v); check("R10 flag clears", v, 16'h0000);
    endtask

    task automatic t_pdwn();
        logic [15:0] v;
        write_reg(1'b0, 16'h0002);
        check("R11 disconnect", {15'b0, xcvr_disconnect_o}, 16'h1);
        read_reg(1'b0, v); check("R12 readback", v, 16'h0002);
        write_reg(1'b0, 16'hFFFC);
        read_reg(1'b0, v); check("R12 reserved zero", v, 16'hFF00);
        check("R11 disconnect off", {15'b0, xcvr_disconnect_o}, 16'h0);
        write_reg(1'b0, 16'h0000);
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_sticky();
        t_clear();
        t_collide();
        t_irq();
        t_endpoints();
        t_fres();
        t_pdwn();
        cyc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule